// File: doc/BRIEF.md
# Deferred Fault Tracker for Hoisted Loads

This block keeps the fault status of loads that were scheduled ahead of their original place in the program. Such a load may hit a fault, for example an invalid address. The fault is not raised when the load completes. The block stores it against the load's destination register as a pending flag plus a fault code.

Later, a check operation placed at the load's original position names that register. If the register holds a pending fault, the block raises an exception carrying the register index and the stored code. It then forgets the fault. If no check for that register ever executes, for instance because the load was on a branch path that was not taken, the fault is dropped and nothing is reported. A flush input discards every pending fault at once.

Top module: `spec_defer_tracker`

## Requirements
- R1: While reset is high, and in the first cycle after it, `exc_valid` is 0, and every register starts with no pending fault.
- R2: A load completion (`ld_valid`=1) with `ld_fault`=1 raises no exception in any cycle because of that completion alone.
- R3: A check (`chk_valid`=1) on a register with a pending fault drives `exc_valid`=1 for exactly one cycle, in the cycle after the check is sampled. In that cycle `exc_reg` equals the checked index and `exc_code` equals the code stored by the faulting load.
- R4: A check that reports a fault clears that register's pending flag, so an immediate second check on it raises nothing.
- R5: A check on a register with no pending fault leaves `exc_valid` at 0.
- R6: A new load to a register replaces its pending state. `ld_fault`=0 clears the flag. `ld_fault`=1 sets it and stores the new `ld_code`.
- R7: `flush`=1 clears every pending flag in one cycle. A load completing in the same cycle as a flush leaves no pending fault.
- R8: When a load and a check name the same register in the same cycle, the check sees the state from before that load, and the load's new state remains afterwards.
- R9: A pending fault whose register is never checked never produces an exception, even while other registers are loaded, checked and raised.
- R10: A check in the same cycle as a flush sees the pre-flush state and can still raise its exception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Hoisted load completes this cycle |
| ld_reg | input | IDX_W (7) | Destination register of the completing load |
| ld_fault | input | 1 | The completing load faulted |
| ld_code | input | CODE_W (4) | Fault code of the completing load |
| chk_valid | input | 1 | Check operation executes this cycle |
| chk_reg | input | IDX_W (7) | Register named by the check |
| flush | input | 1 | Discard all pending faults |
| exc_valid | output | 1 | Exception raised (registered) |
| exc_reg | output | IDX_W (7) | Register index of the raised fault |
| exc_code | output | CODE_W (4) | Fault code of the raised fault |

## Verification
The bench builds the block with its default parameters: 128 registers and a 4-bit fault code. This puts both end indices, 0 and 127, in reach. It also lets a flush be tested against faults spread across the whole register range. A reference model of flags and codes predicts the output for every cycle. This covers same-cycle collisions between a load, a check and a flush, and faults that are never checked.

// File: rtl/spec_defer_pkg.sv
package spec_defer_pkg;
  localparam int unsigned DEF_NUM_REGS = 128;
  localparam int unsigned DEF_CODE_W   = 4;
endpackage

// File: rtl/dfr_flag_bank.sv
module dfr_flag_bank #(
  parameter int unsigned NUM_REGS = 128,
  parameter int unsigned IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             set_val,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_flag
);
  logic [NUM_REGS-1:0] pend;

  // One pending bit per register; the load write has priority over the check clear.
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || flush)
        pend[i] <= 1'b0;
      else if (set_en && set_idx == IDX_W'(i))
        pend[i] <= set_val;
      else if (clr_en && clr_idx == IDX_W'(i))
        pend[i] <= 1'b0;
    end
  end

  // The read returns the state from before this cycle's writes.
  assign rd_flag = pend[rd_idx];

  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (rst)
    flush |=> (pend == '0));

  assert_load_overwrites_R6: assert property (@(posedge clk) disable iff (rst)
    (set_en && !flush) |=> (pend[$past(set_idx)] == $past(set_val)));

  assert_check_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !flush && !(set_en && set_idx == clr_idx)) |=> !pend[$past(clr_idx)]);
endmodule

// File: rtl/dfr_code_ram.sv
module dfr_code_ram #(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned DATA_W = 4,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Simple dual-port memory with a registered read of the old contents.
  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spec_defer_tracker.sv
module spec_defer_tracker
  import spec_defer_pkg::*;
#(
  parameter int unsigned NUM_REGS = DEF_NUM_REGS,
  parameter int unsigned CODE_W   = DEF_CODE_W,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [IDX_W-1:0]  ld_reg,
  input  logic              ld_fault,
  input  logic [CODE_W-1:0] ld_code,
  input  logic              chk_valid,
  input  logic [IDX_W-1:0]  chk_reg,
  input  logic              flush,
  output logic              exc_valid,
  output logic [IDX_W-1:0]  exc_reg,
  output logic [CODE_W-1:0] exc_code
);
  logic hit_flag;

  dfr_flag_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .set_en  (ld_valid),
    .set_idx (ld_reg),
    .set_val (ld_fault),
    .clr_en  (chk_valid),
    .clr_idx (chk_reg),
    .rd_idx  (chk_reg),
    .rd_flag (hit_flag)
  );

  dfr_code_ram #(.DEPTH(NUM_REGS), .DATA_W(CODE_W), .ADDR_W(IDX_W)) u_codes (
    .clk   (clk),
    .we    (ld_valid),
    .waddr (ld_reg),
    .wdata (ld_code),
    .raddr (chk_reg),
    .rdata (exc_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_valid <= 1'b0;
      exc_reg   <= '0;
    end else begin
      exc_valid <= chk_valid && hit_flag;
      exc_reg   <= chk_reg;
    end
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    rst |=> !exc_valid);

  assert_exc_needs_check_R3: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> $past(chk_valid));

  assert_no_raise_on_load_R2: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && !chk_valid) |=> !exc_valid);
endmodule

// File: tb/spec_defer_tracker_test.sv
module spec_defer_tracker_test;
  localparam int unsigned NR = 128;
  localparam int unsigned CW = 4;
  localparam int unsigned IW = $clog2(NR);

  typedef struct {
    logic          v;
    logic [IW-1:0] r;
    logic [CW-1:0] c;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_valid = 1'b0, ld_fault = 1'b0, chk_valid = 1'b0, flush = 1'b0;
  logic [IW-1:0] ld_reg = '0, chk_reg = '0;
  logic [CW-1:0] ld_code = '0;
  logic exc_valid;
  logic [IW-1:0] exc_reg;
  logic [CW-1:0] exc_code;

  int checks = 0, failures = 0;
  exp_t sb[$];
  logic ref_flag [NR];
  logic [CW-1:0] ref_code [NR];

  always #10 clk = ~clk;

  spec_defer_tracker #(.NUM_REGS(NR), .CODE_W(CW)) uut (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_reg(ld_reg), .ld_fault(ld_fault),
    .ld_code(ld_code), .chk_valid(chk_valid), .chk_reg(chk_reg), .flush(flush),
    .exc_valid(exc_valid), .exc_reg(exc_reg), .exc_code(exc_code)
  );

  task automatic step(input logic lv, input int lr, input logic lf, input int lc,
                      input logic cv, input int cr, input logic fl, input string tag);
    exp_t e;
    @(negedge clk);
    ld_valid = lv; ld_reg = IW'(lr); ld_fault = lf; ld_code = CW'(lc);
    chk_valid = cv; chk_reg = IW'(cr); flush = fl;
    e.v = cv && ref_flag[cr];
    e.r = IW'(cr);
    e.c = ref_code[cr];
    e.tag = tag;
    sb.push_back(e);
    if (fl) begin
      for (int i = 0; i < NR; i++) ref_flag[i] = 1'b0;
    end else begin
      if (cv) ref_flag[cr] = 1'b0;
      if (lv) begin ref_flag[lr] = lf; ref_code[lr] = CW'(lc); end
    end
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // Monitor: compare each cycle's registered output against the queued expectation.
  always @(posedge clk) begin
    #5;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (exc_valid !== e.v ||
          (e.v && (exc_reg !== e.r || exc_code !== e.c))) begin
        failures++;
        $display("FAIL %s: got v=%0b reg=%0d code=%0d, expected v=%0b reg=%0d code=%0d",
                 e.tag, exc_valid, exc_reg, exc_code, e.v, e.r, e.c);
      end
    end
  end

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) begin ref_flag[i] = 1'b0; ref_code[i] = '0; end
    repeat (3) @(negedge clk);
    checks++;
    if (exc_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1: got exc_valid=%0b, expected 0", exc_valid);
    end
    rst = 1'b0;
    idle("R1 first cycle");
    step(0, 0, 0, 0, 1, 5, 0, "R1 clear after reset");

    // R2 faulting loads raise nothing; R3 check reports them
    step(1, 0, 1, 9, 0, 0, 0, "R2 load idx0");
    step(1, 127, 1, 6, 0, 0, 0, "R2 load idx127");
    step(0, 0, 0, 0, 1, 0, 0, "R3 check idx0");
    step(0, 0, 0, 0, 1, 0, 0, "R4 recheck idx0");
    step(0, 0, 0, 0, 1, 127, 0, "R3 check idx127");
    step(0, 0, 0, 0, 1, 127, 0, "R4 recheck idx127");

    // R5 check on clean register; non-faulting load
    step(1, 10, 0, 3, 0, 0, 0, "R5 clean load");
    step(0, 0, 0, 0, 1, 10, 0, "R5 check clean");

    // R6 overwrite
    step(1, 20, 1, 2, 0, 0, 0, "R6 first fault");
    step(1, 20, 1, 13, 0, 0, 0, "R6 new code");
    step(0, 0, 0, 0, 1, 20, 0, "R6 check new code");
    step(1, 21, 1, 4, 0, 0, 0, "R6 fault");
    step(1, 21, 0, 0, 0, 0, 0, "R6 clean overwrite");
    step(0, 0, 0, 0, 1, 21, 0, "R6 check cleared");

    // R8 same-cycle load and check
    step(1, 30, 1, 7, 1, 30, 0, "R8 check sees old clear");
    step(0, 0, 0, 0, 1, 30, 0, "R8 load state kept");
    step(1, 31, 1, 1, 0, 0, 0, "R8 setup");
    step(1, 31, 1, 12, 1, 31, 0, "R8 check sees old code");
    step(0, 0, 0, 0, 1, 31, 0, "R8 new code kept");
    step(1, 32, 1, 5, 0, 0, 0, "R8 setup2");
    step(1, 32, 0, 0, 1, 32, 0, "R8 old fault raised");
    step(0, 0, 0, 0, 1, 32, 0, "R8 clean load kept");

    // R7 flush across all registers
    for (int i = 0; i < NR; i += 9) step(1, i, 1, i % 16, 0, 0, 0, "R7 fill");
    step(1, 50, 1, 8, 0, 0, 1, "R7 flush with load");
    for (int i = 0; i < NR; i += 9) step(0, 0, 0, 0, 1, i, 0, "R7 after flush");
    step(0, 0, 0, 0, 1, 50, 0, "R7 load under flush dropped");

    // R10 check during flush
    step(1, 60, 1, 11, 0, 0, 0, "R10 setup");
    step(0, 0, 0, 0, 1, 60, 1, "R10 check with flush");

    // R9 never-checked fault stays silent amid other traffic
    step(1, 70, 1, 15, 0, 0, 0, "R9 unchecked fault");
    for (int i = 0; i < 6; i++) begin
      step(1, 80 + i, 1, i, 1, 80 + i - 1, 0, "R9 other traffic");
    end
    step(0, 0, 0, 0, 1, 71, 0, "R9 neighbour check");
    step(0, 0, 0, 0, 0, 0, 1, "R9 flush drops it");
    step(0, 0, 0, 0, 1, 70, 0, "R9 stays silent");

    repeat (3) idle("drain");
    @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule